// File: doc/BRIEF.md
# Lockable Translation Buffer with Victim Pointer

This block is a small fully associative address translation buffer for a device-side memory management unit. It holds either 8 or 32 entries, set by the `NUM_ENTRIES` parameter; any other count stops elaboration with an error. Each entry keeps a tag word and a data word. The tag word holds a virtual page tag, a page-size code, a preserve flag and a valid flag. The data word holds a physical page base and free attribute bits. A combinational lookup port takes a virtual address. It returns hit, the translated physical address and the page-size code of the matching entry.

Software manages the buffer through eight word registers. A lock register holds two 5-bit fields. One is a base index: entries below it are never chosen for replacement. The other is a victim index, which names the entry that the next load replaces. The same victim index also selects the entry shown by the two read-back registers. Software places a tag and a data word in staging registers and then issues one of three commands: load, flush one page, or flush all entries. The flush-all command leaves preserved entries in place.

Top module: `ltlb`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and reads back as zero. The lock register reads zero and no lookup hits.
- R2: Register indices are: 0 lock, 1 staged tag, 2 staged data, 3 load, 4 flush one page, 5 flush all, 6 victim tag read, 7 victim data read. Any write to index 3, 4 or 5 is a command. In the lock register, bits 14:10 hold the base index and bits 8:4 hold the victim index. All other bits are ignored on write and read as zero.
- R3: A load writes the staged tag, with bit 2 (valid) forced to 1, and the staged data into the entry at the victim index. If the victim index is not below the entry count, the load changes no entry and does not move the victim index.
- R4: After a load at a victim index below the entry count, the victim index advances by one. When the advanced value would equal the entry count, the victim index takes the base index instead.
- R5: Index 6 returns the tag of the entry at the victim index, with bit 2 showing that entry's valid flag. Index 7 returns its data. Both return zero when the victim index is not below the entry count.
- R6: Tag bits 1:0 code the page size: 0 is 4 KB, 1 is 64 KB, 2 is 1 MB, 3 is 16 MB. A valid entry hits when start <= va < start + size, where start is the tag with the bits below the page size cleared. The physical address is the data word's bits above the page offset joined with the lookup address's offset bits.
- R7: When several valid entries hit the same address, the entry with the lowest index supplies the result.
- R8: A flush-one command invalidates every valid entry whose range contains the staged tag's address. It leaves all other entries unchanged.
- R9: A flush-all command invalidates every entry whose tag bit 3 (preserve) is 0. Preserved entries keep their valid flag.
- R10: On a miss, the physical address and page-size outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_pgsz | output | 2 | Page-size code of the hitting entry |

## Verification
The bound checker watches five behaviours on every cycle:
- the victim index stepping forward and wrapping to the base index after each load;
- loads at an out-of-range victim leaving all state untouched;
- no entry still covering the staged address after a flush-one command;
- flush-all sparing exactly the preserved valid entries;
- offset pass-through and zero outputs on the lookup port.

Some behaviour only the bench scenarios can show. These are the exact tag and data contents written by a load and what the read-back registers return, and the lowest-index choice among overlapping pages. They also include the page-size masking of tags that carry stray bits below their page boundary. The bench compares all of these against a model built from the requirements, probing each page edge.

// File: rtl/ltlb_pkg.sv
// Package: shared encodings for the lockable translation buffer.
// Assumes 32-bit register and address words and a 4 KB smallest page.
package ltlb_pkg;

    localparam int WORD_W        = 32;
    localparam int FLD_W         = 5;
    localparam int LOCK_BASE_LSB = 10;
    localparam int LOCK_VICT_LSB = 4;
    localparam int TAG_PRES_BIT  = 3;
    localparam int TAG_VALID_BIT = 2;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pgsz_e;

    typedef enum logic [2:0] {
        RA_LOCK      = 3'd0,
        RA_STG_TAG   = 3'd1,
        RA_STG_DATA  = 3'd2,
        RA_LOAD      = 3'd3,
        RA_FLUSH_ONE = 3'd4,
        RA_FLUSH_ALL = 3'd5,
        RA_VIC_TAG   = 3'd6,
        RA_VIC_DATA  = 3'd7
    } reg_addr_e;

    // Page-number mask for a page-size code: ones above the page offset.
    function automatic logic [WORD_W-1:0] page_mask(input logic [1:0] sz);
        logic [WORD_W-1:0] m;
        case (pgsz_e'(sz))
            PG_4K:   m = 32'hFFFF_F000;
            PG_64K:  m = 32'hFFFF_0000;
            PG_1M:   m = 32'hFFF0_0000;
            default: m = 32'hFF00_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ltlb_entry.sv
// Module: one translation entry with its tag, data and valid flag.
// It compares its page against the lookup address and the flush address.
// Assumes only one of load / flush-one / flush-all is asserted per cycle.
module ltlb_entry
    import ltlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              flush_one_en,
    input  logic              flush_all_en,
    input  logic [WORD_W-1:0] new_tag,
    input  logic [WORD_W-1:0] new_data,
    input  logic [WORD_W-1:0] lk_va,
    input  logic [WORD_W-1:0] fl_va,
    output logic              valid_o,
    output logic              pres_o,
    output logic [WORD_W-1:0] tag_o,
    output logic [WORD_W-1:0] data_o,
    output logic              lk_match_o,
    output logic              fl_match_o
);

    logic              valid_q;
    logic [WORD_W-1:0] tag_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] pmask;

    // Page mask from this entry's size code.
    always_comb pmask = page_mask(tag_q[1:0]);

    // Range compare: masked address equals masked tag.
    always_comb begin
        lk_match_o = valid_q && ((lk_va & pmask) == (tag_q & pmask));
        fl_match_o = valid_q && ((fl_va & pmask) == (tag_q & pmask));
    end

    // Entry storage: load, selective invalidate, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            data_q  <= '0;
        end else if (load_en) begin
            valid_q <= 1'b1;
            tag_q   <= new_tag | (WORD_W'(1) << TAG_VALID_BIT);
            data_q  <= new_data;
        end else if ((flush_one_en && fl_match_o) ||
                     (flush_all_en && !tag_q[TAG_PRES_BIT])) begin
            valid_q <= 1'b0;
        end
    end

    // Read-back view: the valid bit position reflects the live flag.
    always_comb begin
        tag_o   = {tag_q[WORD_W-1:TAG_VALID_BIT+1], valid_q, tag_q[TAG_VALID_BIT-1:0]};
        data_o  = data_q;
        valid_o = valid_q;
        pres_o  = tag_q[TAG_PRES_BIT];
    end

endmodule

// File: rtl/ltlb_vict_ctrl.sv
// Module: base and victim index registers of the lock register.
// The victim steps after each accepted load and wraps to the base.
// Assumes the lock write and the load never arrive in the same cycle.
module ltlb_vict_ctrl
    import ltlb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [FLD_W-1:0] base_wr,
    input  logic [FLD_W-1:0] vict_wr,
    input  logic             load_req,
    output logic [FLD_W-1:0] base_q,
    output logic [FLD_W-1:0] vict_q,
    output logic             vict_ok
);

    localparam logic [FLD_W:0]   CNT_EXT = (FLD_W+1)'(N);
    localparam logic [FLD_W-1:0] LAST    = FLD_W'(N - 1);

    // Victim is usable only while it names an existing entry.
    always_comb vict_ok = ({1'b0, vict_q} < CNT_EXT);

    // Index registers: software write, or advance on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            vict_q <= '0;
        end else if (lock_we) begin
            base_q <= base_wr;
            vict_q <= vict_wr;
        end else if (load_req && vict_ok) begin
            vict_q <= (vict_q == LAST) ? base_q : vict_q + FLD_W'(1);
        end
    end

endmodule

// File: rtl/ltlb_prio.sv
// Module: lowest-index-first priority encoder over the match vector.
// Assumes IW is wide enough to index N entries.
module ltlb_prio #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/ltlb.sv
// Module: lockable fully associative translation buffer (top).
// It holds the staged tag and data registers, decodes commands, and selects
// the lookup result and the register read data.
// Assumes at most one register write per cycle; reads are combinational.
module ltlb
    import ltlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] lk_va,
    output logic              lk_hit,
    output logic [WORD_W-1:0] lk_pa,
    output logic [1:0]        lk_pgsz
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);

    if (!(NUM_ENTRIES == 8 || NUM_ENTRIES == 32)) begin : g_bad_cfg
        $error("ltlb: NUM_ENTRIES must be 8 or 32");
    end

    logic [WORD_W-1:0] stg_tag;
    logic [WORD_W-1:0] stg_data;
    logic              lock_we;
    logic              load_cmd;
    logic              flush_one_cmd;
    logic              flush_all_cmd;
    logic              load_fire;
    logic [FLD_W-1:0]  base_q;
    logic [FLD_W-1:0]  vict_q;
    logic              vict_ok;
    logic [IDX_W-1:0]  vict_idx;

    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] pres_vec;
    logic [NUM_ENTRIES-1:0] lk_match_vec;
    logic [NUM_ENTRIES-1:0] fl_match_vec;
    logic [WORD_W-1:0]      tag_arr  [NUM_ENTRIES];
    logic [WORD_W-1:0]      data_arr [NUM_ENTRIES];

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_any;
    logic [WORD_W-1:0] lk_mask;

    // Command decode from the register index.
    always_comb begin
        lock_we       = reg_we && (reg_addr == RA_LOCK);
        load_cmd      = reg_we && (reg_addr == RA_LOAD);
        flush_one_cmd = reg_we && (reg_addr == RA_FLUSH_ONE);
        flush_all_cmd = reg_we && (reg_addr == RA_FLUSH_ALL);
        load_fire     = load_cmd && vict_ok;
        vict_idx      = vict_q[IDX_W-1:0];
    end

    // Staging registers for the next load or single-page flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_tag  <= '0;
            stg_data <= '0;
        end else if (reg_we && reg_addr == RA_STG_TAG) begin
            stg_tag  <= reg_wdata;
        end else if (reg_we && reg_addr == RA_STG_DATA) begin
            stg_data <= reg_wdata;
        end
    end

    ltlb_vict_ctrl #(.N(NUM_ENTRIES)) u_vict (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_we  (lock_we),
        .base_wr  (reg_wdata[LOCK_BASE_LSB +: FLD_W]),
        .vict_wr  (reg_wdata[LOCK_VICT_LSB +: FLD_W]),
        .load_req (load_cmd),
        .base_q   (base_q),
        .vict_q   (vict_q),
        .vict_ok  (vict_ok)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        ltlb_entry u_ent (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_en      (load_fire && (vict_idx == IDX_W'(i))),
            .flush_one_en (flush_one_cmd),
            .flush_all_en (flush_all_cmd),
            .new_tag      (stg_tag),
            .new_data     (stg_data),
            .lk_va        (lk_va),
            .fl_va        (stg_tag),
            .valid_o      (valid_vec[i]),
            .pres_o       (pres_vec[i]),
            .tag_o        (tag_arr[i]),
            .data_o       (data_arr[i]),
            .lk_match_o   (lk_match_vec[i]),
            .fl_match_o   (fl_match_vec[i])
        );
    end

    ltlb_prio #(.N(NUM_ENTRIES), .IW(IDX_W)) u_prio (
        .req (lk_match_vec),
        .hit (lk_any),
        .idx (lk_idx)
    );

    // Lookup result: page bits from the entry, offset bits from the address.
    always_comb begin
        lk_mask = page_mask(tag_arr[lk_idx][1:0]);
        lk_hit  = lk_any;
        lk_pa   = lk_any ? ((data_arr[lk_idx] & lk_mask) | (lk_va & ~lk_mask)) : '0;
        lk_pgsz = lk_any ? tag_arr[lk_idx][1:0] : 2'd0;
    end

    // Register read mux; read-back follows the victim index.
    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_LOCK:     reg_rdata = (WORD_W'(base_q) << LOCK_BASE_LSB) |
                                     (WORD_W'(vict_q) << LOCK_VICT_LSB);
            RA_STG_TAG:  reg_rdata = stg_tag;
            RA_STG_DATA: reg_rdata = stg_data;
            RA_VIC_TAG:  reg_rdata = vict_ok ? tag_arr[vict_idx]  : '0;
            RA_VIC_DATA: reg_rdata = vict_ok ? data_arr[vict_idx] : '0;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ltlb_chk.sv
// Module: cycle checker for the translation buffer, bound to the top.
// Assumes the signal names of the ltlb top module.
module ltlb_chk
    import ltlb_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_cmd,
    input logic              flush_one_cmd,
    input logic              flush_all_cmd,
    input logic [FLD_W-1:0]  base_q,
    input logic [FLD_W-1:0]  vict_q,
    input logic [N-1:0]      valid_vec,
    input logic [N-1:0]      pres_vec,
    input logic [N-1:0]      fl_match_vec,
    input logic              lk_hit,
    input logic [WORD_W-1:0] lk_va,
    input logic [WORD_W-1:0] lk_pa,
    input logic [1:0]        lk_pgsz
);

    localparam int             IW      = $clog2(N);
    localparam logic [FLD_W:0] CNT_EXT = (FLD_W+1)'(N);
    localparam logic [FLD_W:0] LAST_EX = (FLD_W+1)'(N - 1);

    logic [IW-1:0] vict_d;

    // Remember the victim of the previous cycle.
    always_ff @(posedge clk) vict_d <= vict_q[IW-1:0];

    AST_VICT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cmd && {1'b0, vict_q} < LAST_EX) |=> (vict_q == $past(vict_q) + FLD_W'(1))); // R4
    AST_VICT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cmd && {1'b0, vict_q} == LAST_EX) |=> (vict_q == $past(base_q))); // R4
    AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cmd && {1'b0, vict_q} < CNT_EXT) |=> valid_vec[vict_d]); // R3
    AST_HIGH_VICT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cmd && {1'b0, vict_q} >= CNT_EXT) |=> (valid_vec == $past(valid_vec) && vict_q == $past(vict_q))); // R3
    AST_FLUSH_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_one_cmd |=> (fl_match_vec == '0)); // R8
    AST_FLUSH_ALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all_cmd |=> ((valid_vec & ~$past(pres_vec)) == '0)); // R9
    AST_FLUSH_ALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all_cmd |=> ((valid_vec & $past(pres_vec & valid_vec)) == $past(pres_vec & valid_vec))); // R9
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_pa & ~page_mask(lk_pgsz)) == (lk_va & ~page_mask(lk_pgsz)))); // R6
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0 && lk_pgsz == 2'd0)); // R10

endmodule

bind ltlb ltlb_chk #(.N(NUM_ENTRIES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_cmd      (load_cmd),
    .flush_one_cmd (flush_one_cmd),
    .flush_all_cmd (flush_all_cmd),
    .base_q        (base_q),
    .vict_q        (vict_q),
    .valid_vec     (valid_vec),
    .pres_vec      (pres_vec),
    .fl_match_vec  (fl_match_vec),
    .lk_hit        (lk_hit),
    .lk_va         (lk_va),
    .lk_pa         (lk_pa),
    .lk_pgsz       (lk_pgsz)
);

// File: tb/ltlb_tb_top.sv
// Bench: 8-entry configuration, compared against a model built from the requirements.
module ltlb_tb_top;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] lk_va;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic [1:0]  lk_pgsz;

    always #10 clk = ~clk;

    ltlb #(.NUM_ENTRIES(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_va     (lk_va),
        .lk_hit    (lk_hit),
        .lk_pa     (lk_pa),
        .lk_pgsz   (lk_pgsz)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_tag  [N];
    logic [31:0] m_data [N];
    logic        m_val  [N];
    logic [4:0]  m_base;
    logic [4:0]  m_vict;

    function automatic logic [31:0] pmask(input logic [1:0] s);
        return ~((32'd1 << (12 + 4 * int'(s))) - 32'd1);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_lock(input logic [4:0] b, input logic [4:0] v);
        wr(3'd0, (32'(b) << 10) | (32'(v) << 4));
        m_base = b; m_vict = v;
    endtask

    task automatic check_lock(input string req);
        logic [31:0] v;
        rd(3'd0, v);
        check(req, "lock", v, (32'(m_base) << 10) | (32'(m_vict) << 4));
    endtask

    task automatic do_load(input logic [31:0] t, input logic [31:0] d);
        wr(3'd1, t);
        wr(3'd2, d);
        wr(3'd3, 32'd0);
        if (m_vict < 5'(N)) begin
            m_tag[m_vict[2:0]]  = t | 32'h4;
            m_data[m_vict[2:0]] = d;
            m_val[m_vict[2:0]]  = 1'b1;
            m_vict = (m_vict == 5'(N - 1)) ? m_base : m_vict + 5'd1;
        end
    endtask

    task automatic check_entry(input int i, input string req);
        logic [31:0] t;
        logic [31:0] d;
        logic [4:0]  sv;
        sv = m_vict;
        set_lock(m_base, 5'(i));
        rd(3'd6, t);
        rd(3'd7, d);
        check(req, $sformatf("readback tag %0d", i), t,
              m_val[i] ? m_tag[i] : (m_tag[i] & ~32'h4));
        check(req, $sformatf("readback data %0d", i), d, m_data[i]);
        set_lock(m_base, sv);
    endtask

    task automatic probe(input logic [31:0] va, input string req);
        logic        eh = 1'b0;
        logic [31:0] ep = 32'd0;
        logic [1:0]  es = 2'd0;
        for (int i = N - 1; i >= 0; i--) begin
            logic [31:0] m;
            m = pmask(m_tag[i][1:0]);
            if (m_val[i] && ((va & m) == (m_tag[i] & m))) begin
                eh = 1'b1;
                ep = (m_data[i] & m) | (va & ~m);
                es = m_tag[i][1:0];
            end
        end
        lk_va = va;
        #1;
        check(req, $sformatf("hit @%h", va), {31'd0, lk_hit}, {31'd0, eh});
        check(req, $sformatf("pa @%h", va), lk_pa, ep);
        check(req, $sformatf("pgsz @%h", va), {30'd0, lk_pgsz}, {30'd0, es});
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < N; i++) begin
            logic [31:0] s;
            logic [31:0] b;
            s = m_tag[i] & pmask(m_tag[i][1:0]);
            b = ~pmask(m_tag[i][1:0]) + 32'd1;
            probe(s, req);
            probe(s + b - 32'd1, req);
            probe(s + b, req);
            probe(s - 32'd1, req);
            probe(s | 32'h123, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lt [N];
        logic [31:0] ld [N];
        lt[0] = 32'h0010_0002; ld[0] = 32'h8000_00A5;
        lt[1] = 32'h0000_1008; ld[1] = 32'h1234_5003;
        lt[2] = 32'h0002_0001; ld[2] = 32'h4000_0111;
        lt[3] = 32'h0100_000B; ld[3] = 32'h2000_0000;
        lt[4] = 32'h0010_5000; ld[4] = 32'h7777_7000;
        lt[5] = 32'h0307_8002; ld[5] = 32'h5550_0000;
        lt[6] = 32'hFFFF_F000; ld[6] = 32'h0ABC_D000;
        lt[7] = 32'h0003_0001; ld[7] = 32'h6000_0000;

        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0; lk_va = 32'd0;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = 32'd0; m_data[i] = 32'd0; m_val[i] = 1'b0;
        end
        m_base = 5'd0; m_vict = 5'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_lock("R1");
        rd(3'd6, v); check("R1", "tag readback", v, 32'd0);
        rd(3'd7, v); check("R1", "data readback", v, 32'd0);
        probe(32'h0010_0000, "R10");

        // R2: field positions, stray bits dropped
        wr(3'd0, 32'hFFFF_8000 | (32'd5 << 10) | (32'd3 << 4) | 32'h20F);
        m_base = 5'd5; m_vict = 5'd3;
        check_lock("R2");
        set_lock(5'd0, 5'd0);

        // R3/R4: fill every entry, victim steps then wraps to base 0
        for (int i = 0; i < N; i++) begin
            do_load(lt[i], ld[i]);
            check_lock("R4");
        end
        for (int i = 0; i < N; i++) check_entry(i, "R5");

        // R6/R7/R10: page edges of every entry; entry 0 overlaps entry 4
        sweep("R6");
        probe(32'h0010_5000, "R7");
        probe(32'h0800_0000, "R10");

        // R4: wrap from the last entry goes to the locked base
        set_lock(5'd3, 5'd7);
        do_load(32'h0400_0002, 32'h9990_0055);
        check_lock("R4");
        check_entry(7, "R3");
        sweep("R3");

        // R3/R5: victim beyond the entry count
        set_lock(5'd3, 5'd9);
        do_load(32'h0500_0002, 32'h1110_0000);
        check_lock("R3");
        rd(3'd6, v); check("R5", "out-of-range tag", v, 32'd0);
        rd(3'd7, v); check("R5", "out-of-range data", v, 32'd0);
        probe(32'h0500_0000, "R3");
        set_lock(5'd0, 5'd0);

        // R8: flush one page; both overlapping entries covering it go
        wr(3'd1, 32'h0010_5800);
        wr(3'd4, 32'd0);
        for (int i = 0; i < N; i++) begin
            logic [31:0] m;
            m = pmask(m_tag[i][1:0]);
            if (m_val[i] && ((32'h0010_5800 & m) == (m_tag[i] & m))) m_val[i] = 1'b0;
        end
        sweep("R8");
        probe(32'h0010_5000, "R8");
        check_entry(0, "R8");
        check_entry(4, "R8");

        // R9: flush all keeps only preserved entries (1 and 3)
        wr(3'd5, 32'd0);
        for (int i = 0; i < N; i++) if (!m_tag[i][3]) m_val[i] = 1'b0;
        sweep("R9");
        check_entry(3, "R9");
        check_entry(2, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule